// File: doc/BRIEF.md
# Windowed Display RAM Write Path with Line Commit

This block receives host traffic on a 9-bit parallel bus and turns it into writes into a display frame memory. Each pair of bus transfers forms one 18-bit value. The value is either a register index (select low) or data for the selected register (select high). Data sent while the RAM port index is selected becomes pixel words. The memory location is set by a row/column address counter that stays inside a programmable rectangular window.

The block has two write modes. In per-word mode each finished pixel word is stored at once, and the counter then steps horizontally or vertically inside the window. In line mode the words of a whole window line are gathered in one half of a two-bank buffer. When the line is full, a drain engine copies it into memory one word per cycle at the window's start column of the current row, while the host keeps filling the other bank. Rows sit 0x100 apart, so consecutive lines start 0x100 apart in the flat address space. A read port returns memory contents only while per-word mode is active.

State machines: the pairing machine has states ASM_UPPER and ASM_LOWER. ASM_UPPER moves to ASM_LOWER on any transfer. ASM_LOWER moves to ASM_UPPER on a transfer of the same kind, which emits a word. ASM_LOWER stays in ASM_LOWER on a transfer of the other kind, which becomes the new upper half. The drain machine has states CM_IDLE and CM_DRAIN. CM_IDLE moves to CM_DRAIN when a line completes. CM_DRAIN moves to CM_IDLE after its last word, or stays in CM_DRAIN when another line completes in that same cycle.

Top module: `dram_writer`

## Requirements
- R1: A transfer is taken in any cycle with bus_cs and bus_wr both high. Two consecutive transfers of the same kind form an 18-bit value: the first carries bits 17..9 and the second carries bits 8..0.
- R2: Index 0x202 selects the RAM port. Data sent under any other index never changes memory. Index 0x010 is the mode register: bit 0 selects line mode and bit 1 selects vertical stepping. Index 0x011 is the column window and 0x012 the row window; in each, bits 17..9 hold the end and bits 8..0 the start. Index 0x013 sets the address: bits 17..9 hold the row and bits 8..0 the column.
- R3: In per-word mode with horizontal stepping, each word is stored at once at row*0x100+column. The column then advances. At the window's end column it returns to the start column of the next row, and after the end row it returns to the start row.
- R4: In per-word mode with vertical stepping, the row advances after each word. At the end row it returns to the start row and the column advances, wrapping from the end column to the start column.
- R5: In line mode nothing is stored until the last word of a window line arrives. The line is then stored at the window's start column of the current row, and the row advances with window wrap. Consecutive lines therefore sit 0x100 apart.
- R6: A partly filled line is dropped when an index is written, when the mode register is written, or when an address is set. None of its words reach memory.
- R7: busy is high for exactly one cycle per word of a committed line. It rises the cycle after the line completes. Words for the next line are accepted while busy is high.
- R8: While line mode is set, rd_ok is low and rd_data is zero. In per-word mode rd_ok is high and rd_data shows the word at rd_addr.
- R9: In line mode the vertical-stepping bit has no effect: each line is stored along one row.
- R10: After reset busy is low, rd_ok is high, the mode is per-word with horizontal stepping, and the window covers the whole memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_wr | input | 1 | Write strobe, active high, one cycle per transfer |
| bus_rs | input | 1 | Transfer kind: 0 index, 1 data |
| bus_db | input | 9 | Half of an 18-bit value |
| rd_addr | input | ROW_BITS+COL_BITS | Read address, row in upper bits |
| rd_ok | output | 1 | Read accepted (per-word mode) |
| rd_data | output | 18 | Word at rd_addr, zero when refused |
| busy | output | 1 | Line drain in progress |

## Verification
The hardest case to reach is a line-mode buffer that holds words when it is thrown away. Its contents cannot be read in line mode, so a missing discard only shows up in a later line. The stimulus writes a few spare words and then an address set, an index rewrite or a mode change. It then sends a complete line, or returns to per-word mode, and compares all of memory against the arithmetic model. A leftover word would shift a whole line or add an unexpected commit.

// File: rtl/dw_pkg.sv
`timescale 1ns/1ps
package dw_pkg;
    localparam int BUS_W  = 9;
    localparam int WORD_W = 2 * BUS_W;
    localparam int HALF   = BUS_W;

    localparam logic [WORD_W-1:0] IDX_MODE = 18'h00010;
    localparam logic [WORD_W-1:0] IDX_HWIN = 18'h00011;
    localparam logic [WORD_W-1:0] IDX_VWIN = 18'h00012;
    localparam logic [WORD_W-1:0] IDX_ADDR = 18'h00013;
    localparam logic [WORD_W-1:0] IDX_RAM  = 18'h00202;

    typedef enum logic {ASM_UPPER, ASM_LOWER} asm_st_t;
    typedef enum logic {CM_IDLE, CM_DRAIN} cm_st_t;
endpackage

// File: rtl/dram_bus_pair.sv
`timescale 1ns/1ps
module dram_bus_pair
    import dw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              rs,
    input  logic [BUS_W-1:0]  db,
    output logic              word_v,
    output logic              word_rs,
    output logic [WORD_W-1:0] word
);
    asm_st_t          st_q, st_d;
    logic [BUS_W-1:0] hi_q;
    logic             hi_rs_q;
    logic             xfer;

    assign xfer = cs & wr;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ASM_UPPER: if (xfer) st_d = ASM_LOWER;
            ASM_LOWER: if (xfer && rs == hi_rs_q) st_d = ASM_UPPER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ASM_UPPER;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_v  <= 1'b0;
            word_rs <= 1'b0;
            word    <= '0;
            hi_q    <= '0;
            hi_rs_q <= 1'b0;
        end else begin
            word_v <= 1'b0;
            if (xfer) begin
                if (st_q == ASM_UPPER || rs != hi_rs_q) begin
                    hi_q    <= db;
                    hi_rs_q <= rs;
                end else begin
                    word_v  <= 1'b1;
                    word_rs <= rs;
                    word    <= {hi_q, db};
                end
            end
        end
    end

    // R1: a word only appears right after a second, same-kind transfer
    assert_pair_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_v |-> ($past(st_q) == ASM_LOWER && $past(xfer)));
endmodule

// File: rtl/dram_addr_ctr.sv
`timescale 1ns/1ps
module dram_addr_ctr #(
    parameter int COL_BITS = 8,
    parameter int ROW_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ROW_BITS-1:0] load_row,
    input  logic [COL_BITS-1:0] load_col,
    input  logic                step_word,
    input  logic                step_line,
    input  logic                am,
    input  logic [COL_BITS-1:0] xs,
    input  logic [COL_BITS-1:0] xe,
    input  logic [ROW_BITS-1:0] ys,
    input  logic [ROW_BITS-1:0] ye,
    output logic [ROW_BITS-1:0] row_q,
    output logic [COL_BITS-1:0] col_q
);
    logic [ROW_BITS-1:0] row_nx;
    logic [COL_BITS-1:0] col_nx;

    assign row_nx = (row_q == ye) ? ys : row_q + 1'b1;
    assign col_nx = (col_q == xe) ? xs : col_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            row_q <= load_row;
            col_q <= load_col;
        end else if (step_line) begin
            row_q <= row_nx;
            col_q <= xs;
        end else if (step_word) begin
            if (!am) begin
                col_q <= col_nx;
                if (col_q == xe) row_q <= row_nx;
            end else begin
                row_q <= row_nx;
                if (row_q == ye) col_q <= col_nx;
            end
        end
    end

    // R3: horizontal stepping returns to the start column at the end column
    assert_hwrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_word && !load && !step_line && !am && col_q == xe) |=> (col_q == $past(xs)));

    // R4: vertical stepping returns to the start row at the end row
    assert_vwrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_word && !load && !step_line && am && row_q == ye) |=> (row_q == $past(ys)));
endmodule

// File: rtl/dram_line_buf.sv
`timescale 1ns/1ps
module dram_line_buf
    import dw_pkg::*;
#(
    parameter int COL_BITS = 8,
    parameter int ROW_BITS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WORD_W-1:0]            push_word,
    input  logic                         discard,
    input  logic [COL_BITS:0]            line_len,
    input  logic [ROW_BITS-1:0]          base_row,
    input  logic [COL_BITS-1:0]          base_col,
    output logic                         line_done,
    output logic                         busy,
    output logic                         ram_we,
    output logic [ROW_BITS+COL_BITS-1:0] ram_addr,
    output logic [WORD_W-1:0]            ram_wdata
);
    localparam int DEPTH = 1 << COL_BITS;

    logic [WORD_W-1:0]   mem_q [2][DEPTH];
    logic [COL_BITS:0]   fill_cnt_q;
    logic                fill_bank_q;
    cm_st_t              cm_q, cm_d;
    logic                cbank_q;
    logic [ROW_BITS-1:0] crow_q;
    logic [COL_BITS-1:0] ccol_q;
    logic [COL_BITS:0]   clen_q;
    logic [COL_BITS:0]   cidx_q;
    logic                last_word;

    assign line_done = push && (fill_cnt_q == line_len - 1'b1);
    assign last_word = (cidx_q == clen_q - 1'b1);

    // fill side: write the active bank, flip it when the line is complete
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt_q  <= '0;
            fill_bank_q <= 1'b0;
        end else if (discard) begin
            fill_cnt_q <= '0;
        end else if (push) begin
            if (line_done) begin
                fill_cnt_q  <= '0;
                fill_bank_q <= ~fill_bank_q;
            end else begin
                fill_cnt_q <= fill_cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[fill_bank_q][fill_cnt_q[COL_BITS-1:0]] <= push_word;
    end

    // drain state machine
    always_comb begin
        cm_d = cm_q;
        unique case (cm_q)
            CM_IDLE:  if (line_done) cm_d = CM_DRAIN;
            CM_DRAIN: if (last_word) cm_d = line_done ? CM_DRAIN : CM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cm_q <= CM_IDLE;
        else        cm_q <= cm_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cbank_q <= 1'b0;
            crow_q  <= '0;
            ccol_q  <= '0;
            clen_q  <= '0;
            cidx_q  <= '0;
        end else if (line_done) begin
            cbank_q <= fill_bank_q;
            crow_q  <= base_row;
            ccol_q  <= base_col;
            clen_q  <= line_len;
            cidx_q  <= '0;
        end else if (cm_q == CM_DRAIN) begin
            cidx_q <= cidx_q + 1'b1;
        end
    end

    always_comb begin
        busy      = (cm_q == CM_DRAIN);
        ram_we    = (cm_q == CM_DRAIN);
        ram_addr  = {crow_q, ccol_q + cidx_q[COL_BITS-1:0]};
        ram_wdata = mem_q[cbank_q][cidx_q[COL_BITS-1:0]];
    end

    // R7: a new line may only complete when the drain is idle or on its last word
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && cm_q == CM_DRAIN) |-> last_word);

    // R7: a completed line starts the drain on the next cycle
    assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> busy);
endmodule

// File: rtl/dram_writer.sv
`timescale 1ns/1ps
module dram_writer
    import dw_pkg::*;
#(
    parameter int COL_BITS = 8,
    parameter int ROW_BITS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_cs,
    input  logic                         bus_wr,
    input  logic                         bus_rs,
    input  logic [BUS_W-1:0]             bus_db,
    input  logic [ROW_BITS+COL_BITS-1:0] rd_addr,
    output logic                         rd_ok,
    output logic [WORD_W-1:0]            rd_data,
    output logic                         busy
);
    localparam int ADDR_W = ROW_BITS + COL_BITS;
    localparam int DEPTH  = 1 << ADDR_W;

    logic                word_v, word_rs;
    logic [WORD_W-1:0]   word;
    logic [WORD_W-1:0]   idx_q;
    logic                hs_q, am_q;
    logic [COL_BITS-1:0] xs_q, xe_q;
    logic [ROW_BITS-1:0] ys_q, ye_q;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic                is_idx, is_dat, wr_mode, wr_hwin, wr_vwin, wr_addr;
    logic                ram_port, direct_we, push, discard, line_done;
    logic [COL_BITS:0]   line_len;
    logic                lb_we;
    logic [ADDR_W-1:0]   lb_addr;
    logic [WORD_W-1:0]   lb_data;
    logic [WORD_W-1:0]   ram_q [DEPTH];

    dram_bus_pair pair_i (
        .clk(clk), .rst_n(rst_n), .cs(bus_cs), .wr(bus_wr), .rs(bus_rs), .db(bus_db),
        .word_v(word_v), .word_rs(word_rs), .word(word)
    );

    always_comb begin
        is_idx    = word_v && !word_rs;
        is_dat    = word_v && word_rs;
        wr_mode   = is_dat && idx_q == IDX_MODE;
        wr_hwin   = is_dat && idx_q == IDX_HWIN;
        wr_vwin   = is_dat && idx_q == IDX_VWIN;
        wr_addr   = is_dat && idx_q == IDX_ADDR;
        ram_port  = is_dat && idx_q == IDX_RAM;
        direct_we = ram_port && !hs_q;
        push      = ram_port && hs_q;
        discard   = is_idx || wr_mode || wr_addr;
        line_len  = {1'b0, xe_q} - {1'b0, xs_q} + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            hs_q  <= 1'b0;
            am_q  <= 1'b0;
            xs_q  <= '0;
            xe_q  <= '1;
            ys_q  <= '0;
            ye_q  <= '1;
        end else begin
            if (is_idx) idx_q <= word;
            if (wr_mode) begin
                hs_q <= word[0];
                am_q <= word[1];
            end
            if (wr_hwin) begin
                xs_q <= word[COL_BITS-1:0];
                xe_q <= word[HALF +: COL_BITS];
            end
            if (wr_vwin) begin
                ys_q <= word[ROW_BITS-1:0];
                ye_q <= word[HALF +: ROW_BITS];
            end
        end
    end

    dram_addr_ctr #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) ctr_i (
        .clk(clk), .rst_n(rst_n),
        .load(wr_addr), .load_row(word[HALF +: ROW_BITS]), .load_col(word[COL_BITS-1:0]),
        .step_word(direct_we), .step_line(line_done), .am(am_q),
        .xs(xs_q), .xe(xe_q), .ys(ys_q), .ye(ye_q),
        .row_q(row_q), .col_q(col_q)
    );

    dram_line_buf #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) lbuf_i (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_word(word), .discard(discard),
        .line_len(line_len), .base_row(row_q), .base_col(xs_q),
        .line_done(line_done), .busy(busy),
        .ram_we(lb_we), .ram_addr(lb_addr), .ram_wdata(lb_data)
    );

    always_ff @(posedge clk) begin
        if (lb_we)          ram_q[lb_addr]       <= lb_data;
        else if (direct_we) ram_q[{row_q, col_q}] <= word;
    end

    assign rd_ok   = !hs_q;
    assign rd_data = hs_q ? '0 : ram_q[rd_addr];

    // R5: each completed line moves the counter to the next window row
    assert_line_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && !wr_addr) |=> (row_q == (($past(row_q) == $past(ye_q)) ?
                                     $past(ys_q) : ROW_BITS'($past(row_q) + 1'b1))));

    // R2: the RAM port never stores a value during an index cycle
    assert_idx_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_idx |-> !direct_we && !push);
endmodule

// File: tb/dram_writer_tb_top.sv
`timescale 1ns/1ps
module dram_writer_tb_top;
    localparam int CB = 8;
    localparam int RB = 3;
    localparam int NW = 1 << (CB + RB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs = 1'b0, bus_wr = 1'b0, bus_rs = 1'b0;
    logic [8:0]    bus_db = '0;
    logic [RB+CB-1:0] rd_addr = '0;
    logic          rd_ok, busy;
    logic [17:0]   rd_data;

    int n_chk = 0, n_err = 0;
    int runs = 0, cur_len = 0, last_len = 0;
    logic busy_prev = 1'b0;
    bit   done = 1'b0;
    logic [17:0] exp_m [NW];

    always #2.5 clk = ~clk;

    dram_writer #(.COL_BITS(CB), .ROW_BITS(RB)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rs(bus_rs),
        .bus_db(bus_db), .rd_addr(rd_addr), .rd_ok(rd_ok), .rd_data(rd_data), .busy(busy)
    );

    always @(negedge clk) begin
        if (busy && !busy_prev) begin runs++; cur_len = 1; end
        else if (busy) cur_len++;
        if (!busy && busy_prev) last_len = cur_len;
        busy_prev = busy;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic xfer(input logic k, input logic [8:0] v);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_rs = k; bus_db = v;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic put(input logic k, input logic [17:0] w);
        xfer(k, w[17:9]);
        xfer(k, w[8:0]);
    endtask

    task automatic setreg(input logic [17:0] idx, input logic [17:0] val);
        put(1'b0, idx);
        put(1'b1, val);
    endtask

    task automatic cmp_ram(input string req);
        repeat (4) @(negedge clk);
        for (int a = 0; a < NW; a++) begin
            rd_addr = a[RB+CB-1:0];
            #0.001;
            chk(rd_ok && rd_data == exp_m[a], req, int'(rd_data), int'(exp_m[a]));
        end
    endtask

    function automatic logic [17:0] pat(input int i, input int salt);
        return 18'((i * 18'h0A53 + salt) ^ (i << 9));
    endfunction

    initial begin : main
        int r, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10 busy", busy, 0);
        chk(rd_ok == 1'b1, "R10 rd_ok", rd_ok, 1);

        // R10/R3: reset window covers all; fill memory in horizontal order
        setreg(18'h013, 18'h0);
        put(1'b0, 18'h202);
        for (int i = 0; i < NW; i++) begin
            put(1'b1, pat(i, 7));
            exp_m[i] = pat(i, 7);
        end
        cmp_ram("R10 R1 fill");

        // R3: horizontal stepping in window cols 2..5, rows 1..2
        setreg(18'h011, {9'd5, 9'd2});
        setreg(18'h012, {9'd2, 9'd1});
        setreg(18'h013, {9'd1, 9'd2});
        put(1'b0, 18'h202);
        r = 1; c = 2;
        for (int i = 0; i < 10; i++) begin
            put(1'b1, pat(i, 311));
            exp_m[r * 256 + c] = pat(i, 311);
            if (c == 5) begin c = 2; r = (r == 2) ? 1 : r + 1; end
            else c++;
        end
        cmp_ram("R3");

        // R4: vertical stepping in window cols 10..12, rows 3..5
        setreg(18'h010, 18'h2);
        setreg(18'h011, {9'd12, 9'd10});
        setreg(18'h012, {9'd5, 9'd3});
        setreg(18'h013, {9'd3, 9'd10});
        put(1'b0, 18'h202);
        r = 3; c = 10;
        for (int i = 0; i < 11; i++) begin
            put(1'b1, pat(i, 977));
            exp_m[r * 256 + c] = pat(i, 977);
            if (r == 5) begin r = 3; c = (c == 12) ? 10 : c + 1; end
            else r++;
        end
        cmp_ram("R4");

        // R2: data under an unused index leaves memory unchanged
        setreg(18'h055, 18'h3FFFF);
        for (int i = 0; i < 6; i++) put(1'b1, pat(i, 55));
        cmp_ram("R2");

        // R5 R7 R8 R9: line mode with vertical bit set, cols 16..23, rows 4..6
        setreg(18'h010, 18'h3);
        setreg(18'h011, {9'd23, 9'd16});
        setreg(18'h012, {9'd6, 9'd4});
        setreg(18'h013, {9'd4, 9'd99});
        put(1'b0, 18'h202);
        @(negedge clk);
        rd_addr = 11'h410;
        #0.001;
        chk(rd_ok == 1'b0, "R8 rd_ok", rd_ok, 0);
        chk(rd_data == 18'h0, "R8 rd_data", int'(rd_data), 0);
        runs = 0;
        for (int i = 0; i < 7; i++) put(1'b1, pat(i, 4000));
        repeat (12) @(negedge clk);
        chk(runs == 0, "R5 no early commit", runs, 0);
        put(1'b1, pat(7, 4000));
        repeat (12) @(negedge clk);
        chk(runs == 1, "R7 one commit", runs, 1);
        chk(last_len == 8, "R7 busy length", last_len, 8);
        for (int i = 0; i < 8; i++) exp_m[4 * 256 + 16 + i] = pat(i, 4000);
        r = 5;
        for (int ln = 1; ln < 4; ln++) begin
            for (int i = 0; i < 8; i++) begin
                put(1'b1, pat(ln * 8 + i, 4000));
                exp_m[r * 256 + 16 + i] = pat(ln * 8 + i, 4000);
            end
            r = (r == 6) ? 4 : r + 1;
        end
        repeat (12) @(negedge clk);
        chk(runs == 4, "R7 back-to-back lines", runs, 4);
        chk(last_len == 8, "R7 busy length 2", last_len, 8);

        // R6: partial lines dropped on address set, index rewrite, mode write
        for (int i = 0; i < 5; i++) put(1'b1, pat(i, 9999));
        setreg(18'h013, {9'd5, 9'd0});
        put(1'b0, 18'h202);
        for (int i = 0; i < 8; i++) begin
            put(1'b1, pat(i, 6000));
            exp_m[5 * 256 + 16 + i] = pat(i, 6000);
        end
        for (int i = 0; i < 3; i++) put(1'b1, pat(i, 8888));
        put(1'b0, 18'h202);
        for (int i = 0; i < 8; i++) begin
            put(1'b1, pat(i, 7000));
            exp_m[6 * 256 + 16 + i] = pat(i, 7000);
        end
        for (int i = 0; i < 5; i++) put(1'b1, pat(i, 5555));
        setreg(18'h010, 18'h0);
        repeat (12) @(negedge clk);
        chk(runs == 6, "R6 commit count", runs, 6);
        cmp_ram("R5 R6 R9 lines");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule